// File: doc/BRIEF.md
# Label-Driven Key Builder with Word Table

This block turns a short packet label into a wider key without a table of one key per label. A 16-entry table of 4-bit words is split into sub-tables. A few label bits choose one word from each sub-table in use. In the wide variant, the remaining label bits reorder the chosen words before they are joined into the key. Every entry of the table is distinct, so the sub-table a word came from can be told from its value. A word's position inside the key therefore shows which selection and which reordering produced it, and distinct labels give distinct keys.

A requester holds the label on the label input and pulses the strobe for one cycle. The key appears on a register one cycle later, and a valid flag marks that cycle. The word table resets to a known pattern. It can be rewritten through a small write port. A write is refused in any cycle that carries a strobe, so the key that is being formed always sees a stable table. A compile-time parameter selects the 20-bit key (default) or the 16-bit key variant.

Top module: `kg_key_gen`

## Requirements
- R1: After reset, key_o is 0, key_vld_o is 0, and table entry i holds the value i for i = 0..15.
- R2: key_vld_o is 1 in exactly those cycles that follow a cycle with lbl_vld_i high, and 0 otherwise.
- R3: key_o changes only in the cycle after a strobe. Label changes without a strobe leave it unchanged.
- R4: With KEY_W=20, selected word k (k = 0..4) is table entry 2k + lbl_i[k]. The table is seen as eight two-word sub-tables, of which sub-tables 0..4 are used.
- R5: With KEY_W=20, words 0..3 form a group x0..x3 that is permuted as y[i] = x[i XOR c], where c = {lbl_i[6], lbl_i[5]}. For example, c = 01 gives y0..y3 = x1, x0, x3, x2.
- R6: With KEY_W=20 and lbl_i[7] = 0, key_o[15:0] = {y3,y2,y1,y0} and key_o[19:16] = word 4. With lbl_i[7] = 1, key_o[3:0] = word 4 and key_o[19:4] = {y3,y2,y1,y0}.
- R7: With KEY_W=16, nibble k of key_o (bits 4k+3:4k) is table entry 4k + lbl_i[2k+1:2k]. All eight label bits select, and no reordering occurs.
- R8: A write with wr_en_i high and lbl_vld_i low stores wr_data_i at wr_addr_i on that clock edge. Keys requested afterwards use the new value.
- R9: A write in a cycle with lbl_vld_i high is ignored: the table entry keeps its old value.
- R10: With the reset table, all 256 labels produce 256 distinct keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lbl_vld_i | input | 1 | Strobe: request a key for lbl_i |
| lbl_i | input | LBL_W (8) | Packet label |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | log2(TBL_DEPTH) (4) | Table write address |
| wr_data_i | input | WORD_W (4) | Table write data |
| key_o | output | KEY_W (20) | Registered key |
| key_vld_o | output | 1 | Key valid, one cycle after the strobe |

## Verification
The assertions check the cycle-level contract on every cycle. The valid flag tracks the strobe one cycle later, the key holds between requests, an accepted write lands at its address, and the table is frozen in any cycle that carries a strobe. The mapping from label to key can only be shown by the bench's scenarios. These cover which word each label bit selects, the XOR permutation under every control value, the group swap, the 16-bit variant, and the distinctness of keys over all labels. The bench also proves a refused write at the ports, by requesting a key that reads the entry it targeted.

// File: rtl/kg_pkg.sv
package kg_pkg;
  localparam int unsigned KG_WORD_W    = 4;
  localparam int unsigned KG_TBL_DEPTH = 16;
  localparam int unsigned KG_LBL_W     = 8;
  localparam int unsigned KG_GRP       = 4;  // words in the permuted group
endpackage

// File: rtl/kg_table.sv
module kg_table #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 4,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          blk_i,
  input  logic [AW-1:0]                 wr_addr_i,
  input  logic [WORD_W-1:0]             wr_data_i,
  output logic [DEPTH-1:0][WORD_W-1:0]  tbl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) tbl_o[i] <= WORD_W'(i);
    end else if (wr_en_i && !blk_i) begin
      tbl_o[wr_addr_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/kg_select.sv
module kg_select #(
  parameter int unsigned NW     = 5,
  parameter int unsigned SUB    = 2,
  parameter int unsigned WORD_W = 4,
  parameter int unsigned AW     = 4,
  localparam int unsigned SB    = $clog2(SUB),
  localparam int unsigned ENT   = NW * SUB
) (
  input  logic [ENT-1:0][WORD_W-1:0] tbl_i,
  input  logic [NW*SB-1:0]           sel_i,
  output logic [NW-1:0][WORD_W-1:0]  words_o
);
  for (genvar k = 0; k < int'(NW); k++) begin : g_word
    logic [AW-1:0] addr;
    assign addr       = AW'(k * SUB) + AW'(sel_i[k*SB +: SB]);
    assign words_o[k] = tbl_i[addr];
  end
endmodule

// File: rtl/kg_shuffle.sv
module kg_shuffle #(
  parameter int unsigned KEY_W  = 20,
  parameter int unsigned WORD_W = 4,
  parameter int unsigned NW     = 5,
  parameter int unsigned GRP    = 4,
  localparam int unsigned GB    = $clog2(GRP)
) (
  input  logic [NW-1:0][WORD_W-1:0] words_i,
  input  logic [GB:0]               ctl_i,   // [GB] group swap, [GB-1:0] permutation
  output logic [KEY_W-1:0]          key_o
);
  if (KEY_W == 16) begin : g_plain
    logic unused_ctl;
    assign unused_ctl = ^ctl_i;
    assign key_o      = words_i;
  end else begin : g_perm
    logic [GRP-1:0][WORD_W-1:0] grp_y;
    logic [WORD_W-1:0]          tail_w;
    assign tail_w = words_i[GRP];
    for (genvar i = 0; i < int'(GRP); i++) begin : g_y
      logic [GB-1:0] idx;
      assign idx      = GB'(i) ^ ctl_i[GB-1:0];
      assign grp_y[i] = words_i[idx];
    end
    assign key_o = ctl_i[GB] ? {grp_y, tail_w} : {tail_w, grp_y};
  end
endmodule

// File: rtl/kg_key_gen.sv
module kg_key_gen
  import kg_pkg::*;
#(
  parameter int unsigned KEY_W     = 20,
  parameter int unsigned WORD_W    = KG_WORD_W,
  parameter int unsigned TBL_DEPTH = KG_TBL_DEPTH,
  parameter int unsigned LBL_W     = KG_LBL_W,
  localparam int unsigned AW       = $clog2(TBL_DEPTH),
  localparam int unsigned NW       = KEY_W / WORD_W,
  localparam int unsigned SUB      = (KEY_W == 16) ? 4 : 2,
  localparam int unsigned SB       = $clog2(SUB),
  localparam int unsigned GB       = $clog2(KG_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lbl_vld_i,
  input  logic [LBL_W-1:0]  lbl_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              key_vld_o
);
  logic [TBL_DEPTH-1:0][WORD_W-1:0] tbl_q;
  logic [NW-1:0][WORD_W-1:0]        words;
  logic [KEY_W-1:0]                 key_d;

  kg_table #(.DEPTH(TBL_DEPTH), .WORD_W(WORD_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .blk_i     (lbl_vld_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tbl_o     (tbl_q)
  );

  kg_select #(.NW(NW), .SUB(SUB), .WORD_W(WORD_W), .AW(AW)) u_select (
    .tbl_i   (tbl_q[NW*SUB-1:0]),
    .sel_i   (lbl_i[NW*SB-1:0]),
    .words_o (words)
  );

  kg_shuffle #(.KEY_W(KEY_W), .WORD_W(WORD_W), .NW(NW), .GRP(KG_GRP)) u_shuffle (
    .words_i (words),
    .ctl_i   (lbl_i[LBL_W-1 -: GB+1]),
    .key_o   (key_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o     <= '0;
      key_vld_o <= 1'b0;
    end else begin
      key_vld_o <= lbl_vld_i;
      if (lbl_vld_i) key_o <= key_d;
    end
  end
endmodule

// File: rtl/kg_key_gen_chk.sv
module kg_key_gen_chk #(
  parameter int unsigned KEY_W     = 20,
  parameter int unsigned WORD_W    = 4,
  parameter int unsigned TBL_DEPTH = 16,
  localparam int unsigned AW       = $clog2(TBL_DEPTH)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             lbl_vld_i,
  input logic                             wr_en_i,
  input logic [AW-1:0]                    wr_addr_i,
  input logic [WORD_W-1:0]                wr_data_i,
  input logic [KEY_W-1:0]                 key_o,
  input logic                             key_vld_o,
  input logic [TBL_DEPTH-1:0][WORD_W-1:0] tbl_q
);
  a_r2_vld_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbl_vld_i |=> key_vld_o);
  a_r2_vld_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lbl_vld_i |=> !key_vld_o);
  a_r3_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lbl_vld_i |=> $stable(key_o));
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !lbl_vld_i) |=> tbl_q[$past(wr_addr_i)] == $past(wr_data_i));
  a_r9_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbl_vld_i |=> $stable(tbl_q));
endmodule

bind kg_key_gen kg_key_gen_chk #(.KEY_W(KEY_W), .WORD_W(WORD_W), .TBL_DEPTH(TBL_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lbl_vld_i (lbl_vld_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .key_o     (key_o),
  .key_vld_o (key_vld_o),
  .tbl_q     (tbl_q)
);

// File: tb/kg_key_gen_test.sv
`timescale 1ns/1ps
module kg_key_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lbl_vld = 1'b0;
  logic [7:0] lbl = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [19:0] key20;
  logic [15:0] key16;
  logic        vld20, vld16;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0]  mt [16];
  logic [19:0] seen [256];

  always #10 clk = ~clk;

  kg_key_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .lbl_vld_i(lbl_vld), .lbl_i(lbl),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .key_o(key20), .key_vld_o(vld20));

  kg_key_gen #(.KEY_W(16)) uut16 (
    .clk_i(clk), .rst_ni(rst_n), .lbl_vld_i(lbl_vld), .lbl_i(lbl),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .key_o(key16), .key_vld_o(vld16));

  // {label, expected 20-bit key} with the reset table
  localparam logic [27:0] VEC [6] = '{
    {8'h00, 20'h86420},   // R4 low words
    {8'h1F, 20'h97531},   // R4 high words
    {8'h20, 20'h84602},   // R5 c=01
    {8'h60, 20'h80246},   // R5 c=11
    {8'h80, 20'h64208},   // R6 swap
    {8'hE5, 20'h12568}    // R4 R5 R6 mixed
  };

  function automatic logic [19:0] mdl20(input logic [7:0] l);
    logic [3:0] w [5];
    logic [3:0] y [4];
    for (int k = 0; k < 5; k++) w[k] = mt[2*k + int'(l[k])];
    for (int i = 0; i < 4; i++) y[i] = w[i ^ int'(l[6:5])];
    return l[7] ? {y[3], y[2], y[1], y[0], w[4]} : {w[4], y[3], y[2], y[1], y[0]};
  endfunction

  function automatic logic [15:0] mdl16(input logic [7:0] l);
    logic [15:0] r;
    for (int k = 0; k < 4; k++) r[4*k +: 4] = mt[4*k + int'(l[2*k +: 2])];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic request(input logic [7:0] l);
    @(negedge clk);
    lbl_vld = 1'b1;
    lbl = l;
    @(negedge clk);
    lbl_vld = 1'b0;
  endtask

  task automatic write(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] k0;
    bit distinct;
    for (int i = 0; i < 16; i++) mt[i] = 4'(i);
    #5;
    check("R1 key after reset", 32'(key20), 32'h0);
    check("R1 vld after reset", 32'(vld20), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 key held after reset", 32'(key20), 32'h0);
    check("R2 vld idle", 32'(vld20), 32'h0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      request(VEC[v][27:20]);
      check("R4 R5 R6 vector", 32'(key20), 32'(VEC[v][19:0]));
      check("R2 vld after strobe", 32'(vld20), 32'h1);
    end
    @(negedge clk);
    check("R2 vld drops", 32'(vld20), 32'h0);

    // hold without strobe
    request(8'h1F);
    k0 = key20;
    lbl = 8'h00;
    repeat (3) @(negedge clk);
    check("R3 key holds on label change", 32'(key20), 32'(k0));

    // all four permutation codes
    for (int c = 0; c < 4; c++) begin
      request({1'b0, 2'(c), 5'h00});
      check("R5 permutation code", 32'(key20), 32'(mdl20({1'b0, 2'(c), 5'h00})));
    end

    // 16-bit variant directed
    request(8'h00);
    check("R7 16-bit zero label", 32'(key16), 32'hC840);
    request(8'hFF);
    check("R7 16-bit ones label", 32'(key16), 32'hFB73);
    request(8'h1B);
    check("R7 16-bit mixed label", 32'(key16), 32'hC963);

    // full sweep, both variants; R1 reset table seen via every entry
    for (int l = 0; l < 256; l++) begin
      request(8'(l));
      check("R4 R5 R6 sweep", 32'(key20), 32'(mdl20(8'(l))));
      check("R7 sweep", 32'(key16), 32'(mdl16(8'(l))));
      seen[l] = key20;
    end
    distinct = 1;
    for (int a = 0; a < 256; a++)
      for (int b = a + 1; b < 256; b++)
        if (seen[a] == seen[b]) distinct = 0;
    check("R10 distinct keys", 32'(distinct), 32'h1);

    // accepted write
    write(4'h0, 4'hF);
    mt[0] = 4'hF;
    request(8'h00);
    check("R8 write used", 32'(key20), 32'h8642F);
    check("R8 write used 16", 32'(key16), 32'(mdl16(8'h00)));

    // write during strobe is refused
    @(negedge clk);
    lbl_vld = 1'b1; lbl = 8'h00;
    wr_en = 1'b1; wr_addr = 4'h2; wr_data = 4'hA;
    @(negedge clk);
    lbl_vld = 1'b0; wr_en = 1'b0;
    check("R9 key during blocked write", 32'(key20), 32'h8642F);
    request(8'h00);
    check("R9 entry unchanged", 32'(key20), 32'h8642F);

    write(4'h2, 4'hA);
    mt[2] = 4'hA;
    request(8'h00);
    check("R8 second write", 32'(key20), 32'h864AF);
    check("R8 second write 16", 32'(key16), 32'(mdl16(8'h00)));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule